// File: doc/BRIEF.md
# Block Interleaver with Zero Padding

The block spreads neighbouring coded bits apart before modulation and puts them back in order on the receive side. On the transmit side it takes one 2-bit coded symbol per accepted cycle and gathers 26 of them into a 52-bit linear block. It then presents that block, scrambled by a fixed index permutation, as one parallel word to a downstream symbol mapper. A stream can end part-way through a block. When that happens, the symbol marked as final closes the block, and every position not yet written reads as zero.

On the receive side the block takes 4-bit symbols. Thirteen of them fill a 52-bit block. The inverse permutation is applied, and the linear block is drained as 26 two-bit symbols toward a decoder. The two permutations are exact inverses, so a block that passes through both paths comes back unchanged. Both edges use valid/ready handshakes. Neither path accepts new input while a finished block is still waiting to be taken.

Top module: `blk_ilv`

## Requirements
- R1: After reset, `ilv_ready_o` and `dlv_ready_o` are 1, and `ilv_blk_valid_o` and `dlv_valid_o` are 0.
- R2: The k-th symbol accepted on the transmit side (k = 0..25) is stored at linear bit 2k (`ilv_data_i[0]`) and linear bit 2k+1 (`ilv_data_i[1]`).
- R3: `ilv_blk_valid_o` rises on the cycle after the 26th accepted symbol, or after a symbol accepted with `ilv_last_i` = 1, and at no other time. While it is high, `ilv_ready_o` is 0.
- R4: Linear bit i appears at output bit (17*i) mod 52 of `ilv_blk_o`.
- R5: A block closed by `ilv_last_i` holds zeros in every linear position it did not receive, and shows `ilv_blk_last_o` = 1. A block closed by count alone shows `ilv_blk_last_o` = 0.
- R6: A presented block keeps its value until `ilv_blk_ready_i` is 1. When `ilv_blk_ready_i` is held at 1, `ilv_blk_valid_o` is a single-cycle pulse. After the block is taken, the next block starts empty at position 0.
- R7: On the receive side, nibble k (k = 0..12) fills received bits 4k..4k+3 (`dlv_data_i[b]` goes to bit 4k+b). Linear bit i is received bit (17*i) mod 52. The output emits linear bits {2k+1, 2k} for k = 0..25 in order, and `dlv_last_o` marks k = 25.
- R8: While the receive side drains, `dlv_ready_o` is 0, and `dlv_data_o` and `dlv_last_o` hold while `dlv_ready_i` is 0. After the 26th symbol is taken, `dlv_ready_o` returns to 1.
- R9: Feeding `ilv_blk_o` into the receive side as 13 nibbles (bits 4k..4k+3) returns the zero-padded symbol stream that entered the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ilv_valid_i | input | 1 | Transmit symbol valid |
| ilv_data_i | input | 2 | Transmit coded symbol |
| ilv_last_i | input | 1 | Final symbol of the stream; closes and pads the block |
| ilv_ready_o | output | 1 | Transmit side can accept a symbol |
| ilv_blk_o | output | 52 | Permuted block, parallel |
| ilv_blk_valid_o | output | 1 | Permuted block present |
| ilv_blk_last_o | output | 1 | Present block was closed by the final symbol |
| ilv_blk_ready_i | input | 1 | Downstream takes the block |
| dlv_valid_i | input | 1 | Receive nibble valid |
| dlv_data_i | input | 4 | Receive 4-bit symbol |
| dlv_ready_o | output | 1 | Receive side can accept a nibble |
| dlv_data_o | output | 2 | De-interleaved 2-bit symbol |
| dlv_valid_o | output | 1 | De-interleaved symbol valid |
| dlv_last_o | output | 1 | Final symbol of the block |
| dlv_ready_i | input | 1 | Decoder takes the symbol |

## Verification
The following rules are checked on every cycle:
- both sides stay stalled while a block is pending;
- a presented block and a draining symbol hold through backpressure;
- the transmit block closes exactly on the 26th symbol or on the final-symbol flag, and on no other;
- the last flags appear only with their valid.

The bench scenarios are the only evidence for the actual bit placement and the zero padding. It compares each permuted block against a permutation it computes itself. It also sends every block back through the receive side and checks that the round trip gives the identity.

// File: rtl/blk_ilv_pkg.sv
package blk_ilv_pkg;
  localparam int unsigned BLK_W    = 52;
  localparam int unsigned TX_SYM_W = 2;
  localparam int unsigned RX_SYM_W = 4;
  // out bit (STEP*i)%BLK_W <- linear bit i ; STEP*STEP_INV == 1 mod BLK_W
  localparam int unsigned STEP     = 17;
  localparam int unsigned STEP_INV = 49;
endpackage

// File: rtl/ilv_collect.sv
module ilv_collect #(
  parameter int unsigned W     = 52,
  parameter int unsigned SYM_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SYM_W-1:0] data_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic             full_o,
  output logic             last_o,
  output logic [W-1:0]     blk_o,
  input  logic             take_i
);
  localparam int unsigned NSYM = W / SYM_W;
  localparam int unsigned CW   = $clog2(NSYM);

  logic [W-1:0]  buf_q;
  logic [CW-1:0] cnt_q;
  logic          full_q, last_q;
  logic          acc;

  assign acc     = valid_i && !full_q;
  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign last_o  = last_q;
  assign blk_o   = buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else if (take_i) begin
      buf_q  <= '0;   // unwritten positions of the next block read as zero
      cnt_q  <= '0;
      full_q <= 1'b0;
      last_q <= 1'b0;
    end else if (acc) begin
      for (int k = 0; k < int'(NSYM); k++)
        if (cnt_q == CW'(k)) buf_q[k*SYM_W +: SYM_W] <= data_i;
      if (cnt_q == CW'(NSYM-1) || last_i) begin
        full_q <= 1'b1;
        last_q <= last_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ilv_perm_net.sv
module ilv_perm_net #(
  parameter int unsigned W    = 52,
  parameter int unsigned MULT = 17
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar j = 0; j < W; j++) begin : g_bit
    assign out_o[j] = in_i[(j*MULT) % W];
  end
endmodule

// File: rtl/ilv_drain.sv
module ilv_drain #(
  parameter int unsigned W     = 52,
  parameter int unsigned SYM_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             full_i,
  input  logic [W-1:0]     lin_i,
  output logic             valid_o,
  output logic [SYM_W-1:0] data_o,
  output logic             last_o,
  input  logic             ready_i,
  output logic             done_o
);
  localparam int unsigned NOUT = W / SYM_W;
  localparam int unsigned CW   = $clog2(NOUT);

  logic [CW-1:0] idx_q;
  logic          step;

  assign valid_o = full_i;
  assign last_o  = full_i && (idx_q == CW'(NOUT-1));
  assign step    = full_i && ready_i;
  assign done_o  = step && last_o;

  always_comb begin
    data_o = '0;
    for (int k = 0; k < int'(NOUT); k++)
      if (idx_q == CW'(k)) data_o = lin_i[k*SYM_W +: SYM_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (done_o)  idx_q <= '0;
    else if (step)    idx_q <= idx_q + 1'b1;
  end
endmodule

// File: rtl/blk_ilv.sv
module blk_ilv
  import blk_ilv_pkg::*;
#(
  parameter int unsigned W     = BLK_W,
  parameter int unsigned TXW   = TX_SYM_W,
  parameter int unsigned RXW   = RX_SYM_W,
  parameter int unsigned FWD   = STEP,
  parameter int unsigned INV   = STEP_INV
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ilv_valid_i,
  input  logic [TXW-1:0] ilv_data_i,
  input  logic           ilv_last_i,
  output logic           ilv_ready_o,
  output logic [W-1:0]   ilv_blk_o,
  output logic           ilv_blk_valid_o,
  output logic           ilv_blk_last_o,
  input  logic           ilv_blk_ready_i,
  input  logic           dlv_valid_i,
  input  logic [RXW-1:0] dlv_data_i,
  output logic           dlv_ready_o,
  output logic [TXW-1:0] dlv_data_o,
  output logic           dlv_valid_o,
  output logic           dlv_last_o,
  input  logic           dlv_ready_i
);
  logic [W-1:0] tx_lin;
  logic         tx_full, tx_take;

  ilv_collect #(.W(W), .SYM_W(TXW)) u_tx_col (
    .clk_i, .rst_ni,
    .valid_i (ilv_valid_i),
    .data_i  (ilv_data_i),
    .last_i  (ilv_last_i),
    .ready_o (ilv_ready_o),
    .full_o  (tx_full),
    .last_o  (ilv_blk_last_o),
    .blk_o   (tx_lin),
    .take_i  (tx_take)
  );

  // out[j] = lin[(j*INV)%W]  <=>  out[(i*FWD)%W] = lin[i]
  ilv_perm_net #(.W(W), .MULT(INV)) u_tx_perm (.in_i(tx_lin), .out_o(ilv_blk_o));

  assign ilv_blk_valid_o = tx_full;
  assign tx_take         = tx_full && ilv_blk_ready_i;

  logic [W-1:0] rx_raw, rx_lin;
  logic         rx_full, rx_done, rx_last_nc;

  ilv_collect #(.W(W), .SYM_W(RXW)) u_rx_col (
    .clk_i, .rst_ni,
    .valid_i (dlv_valid_i),
    .data_i  (dlv_data_i),
    .last_i  (1'b0),
    .ready_o (dlv_ready_o),
    .full_o  (rx_full),
    .last_o  (rx_last_nc),
    .blk_o   (rx_raw),
    .take_i  (rx_done)
  );

  // lin[i] = raw[(i*FWD)%W]
  ilv_perm_net #(.W(W), .MULT(FWD)) u_rx_perm (.in_i(rx_raw), .out_o(rx_lin));

  ilv_drain #(.W(W), .SYM_W(TXW)) u_rx_drain (
    .clk_i, .rst_ni,
    .full_i  (rx_full),
    .lin_i   (rx_lin),
    .valid_o (dlv_valid_o),
    .data_o  (dlv_data_o),
    .last_o  (dlv_last_o),
    .ready_i (dlv_ready_i),
    .done_o  (rx_done)
  );
endmodule

// File: rtl/blk_ilv_chk.sv
module blk_ilv_chk #(
  parameter int unsigned W   = 52,
  parameter int unsigned TXW = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           ilv_valid_i,
  input logic           ilv_last_i,
  input logic           ilv_ready_o,
  input logic [W-1:0]   ilv_blk_o,
  input logic           ilv_blk_valid_o,
  input logic           ilv_blk_last_o,
  input logic           ilv_blk_ready_i,
  input logic           dlv_ready_o,
  input logic [TXW-1:0] dlv_data_o,
  input logic           dlv_valid_o,
  input logic           dlv_last_o,
  input logic           dlv_ready_i
);
  localparam int unsigned NSYM = W / TXW;
  localparam int unsigned CW   = $clog2(NSYM);

  logic [CW-1:0] seen_q;
  logic          tx_acc;
  assign tx_acc = ilv_valid_i && ilv_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (tx_acc) seen_q <= (ilv_last_i || seen_q == CW'(NSYM-1)) ? '0 : seen_q + 1'b1;
  end

  p_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilv_blk_valid_o |-> !ilv_ready_o);
  p_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_acc && !ilv_last_i && seen_q != CW'(NSYM-1)) |=> !ilv_blk_valid_o);
  p_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_acc && (ilv_last_i || seen_q == CW'(NSYM-1))) |=>
      (ilv_blk_valid_o && ilv_blk_last_o == $past(ilv_last_i)));
  p_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilv_blk_last_o |-> ilv_blk_valid_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilv_blk_valid_o && !ilv_blk_ready_i) |=> (ilv_blk_valid_o && $stable(ilv_blk_o)));
  p_dlast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_last_o |-> dlv_valid_o);
  p_dstall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_o |-> !dlv_ready_o);
  p_dhold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && !dlv_ready_i) |=>
      (dlv_valid_o && $stable(dlv_data_o) && $stable(dlv_last_o)));
endmodule

bind blk_ilv blk_ilv_chk #(.W(W), .TXW(TXW)) chk_i (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .ilv_valid_i     (ilv_valid_i),
  .ilv_last_i      (ilv_last_i),
  .ilv_ready_o     (ilv_ready_o),
  .ilv_blk_o       (ilv_blk_o),
  .ilv_blk_valid_o (ilv_blk_valid_o),
  .ilv_blk_last_o  (ilv_blk_last_o),
  .ilv_blk_ready_i (ilv_blk_ready_i),
  .dlv_ready_o     (dlv_ready_o),
  .dlv_data_o      (dlv_data_o),
  .dlv_valid_o     (dlv_valid_o),
  .dlv_last_o      (dlv_last_o),
  .dlv_ready_i     (dlv_ready_i)
);

// File: tb/blk_ilv_tb_top.sv
`timescale 1ns/1ps
module blk_ilv_tb_top;
  localparam int W = 52;
  localparam int NV = 6;
  // {last flag, symbol count, linear pattern}
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 6'd26, 52'hF_FFFF_FFFF_FFFF},
    {1'b0, 6'd26, 52'hA_5A5A_5A5A_5A5A},
    {1'b1, 6'd26, 52'h1_2345_6789_ABCD},
    {1'b1, 6'd10, 52'hF_FFFF_FFFF_FFFF},
    {1'b1, 6'd1,  52'h0_0000_0000_0003},
    {1'b0, 6'd26, 52'h8_0000_0000_0001}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic         ilv_valid, ilv_last, ilv_ready, ilv_bv, ilv_bl, ilv_br;
  logic [1:0]   ilv_data;
  logic [W-1:0] ilv_blk;
  logic         dlv_valid, dlv_ready, dlv_v, dlv_l, dlv_r;
  logic [3:0]   dlv_data;
  logic [1:0]   dlv_q;

  blk_ilv dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ilv_valid_i(ilv_valid), .ilv_data_i(ilv_data), .ilv_last_i(ilv_last),
    .ilv_ready_o(ilv_ready), .ilv_blk_o(ilv_blk), .ilv_blk_valid_o(ilv_bv),
    .ilv_blk_last_o(ilv_bl), .ilv_blk_ready_i(ilv_br),
    .dlv_valid_i(dlv_valid), .dlv_data_i(dlv_data), .dlv_ready_o(dlv_ready),
    .dlv_data_o(dlv_q), .dlv_valid_o(dlv_v), .dlv_last_o(dlv_l), .dlv_ready_i(dlv_r)
  );

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] perm_fwd(input logic [W-1:0] lin);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++) r[(i*17) % W] = lin[i];
    return r;
  endfunction

  // feed the receive side with blk, drain and compare against lin; optional stall at symbol 5
  task automatic rx_round(input logic [W-1:0] blk, input logic [W-1:0] lin, input bit stall);
    for (int k = 0; k < 13; k++) begin
      @(negedge clk);
      chk(dlv_ready === 1'b1, "R8 ready while filling", 64'(dlv_ready), 64'd1);
      dlv_valid = 1'b1; dlv_data = blk[4*k +: 4];
      @(posedge clk);
    end
    @(negedge clk);
    dlv_valid = 1'b0;
    chk(dlv_ready === 1'b0, "R8 stalled while draining", 64'(dlv_ready), 64'd0);
    dlv_r = 1'b1;
    for (int k = 0; k < 26; k++) begin
      chk(dlv_v === 1'b1 && dlv_q === lin[2*k +: 2], "R7/R9 symbol", 64'(dlv_q), 64'(lin[2*k +: 2]));
      chk(dlv_l === (k == 25), "R7 last flag", 64'(dlv_l), 64'(k == 25));
      if (stall && k == 5) begin
        dlv_r = 1'b0;
        @(negedge clk);
        chk(dlv_q === lin[2*k +: 2] && dlv_v === 1'b1, "R8 hold under stall", 64'(dlv_q), 64'(lin[2*k +: 2]));
        dlv_r = 1'b1;
      end
      @(negedge clk);
    end
    dlv_r = 1'b0;
    chk(dlv_v === 1'b0 && dlv_ready === 1'b1, "R8 drain done", 64'({dlv_v, dlv_ready}), 64'b01);
  endtask

  initial begin
    rst_n = 1'b0;
    ilv_valid = 0; ilv_last = 0; ilv_data = 0; ilv_br = 0;
    dlv_valid = 0; dlv_data = 0; dlv_r = 0;
    repeat (3) @(negedge clk);
    chk(ilv_ready === 1 && ilv_bv === 0 && dlv_ready === 1 && dlv_v === 0, "R1 reset state",
        64'({ilv_ready, ilv_bv, dlv_ready, dlv_v}), 64'b1010);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic         lst  = VEC[v][58];
      int           ns   = int'(VEC[v][57:52]);
      logic [W-1:0] pat  = VEC[v][51:0];
      logic [W-1:0] lin  = '0;
      logic [W-1:0] got;
      for (int b = 0; b < 2*ns; b++) lin[b] = pat[b];
      for (int k = 0; k < ns; k++) begin
        @(negedge clk);
        if (k == ns - 1 && ns > 1)
          chk(ilv_bv === 1'b0, "R3 no block before close", 64'(ilv_bv), 64'd0);
        ilv_valid = 1'b1; ilv_data = pat[2*k +: 2]; ilv_last = lst && (k == ns - 1);
        @(posedge clk);
      end
      @(negedge clk);
      ilv_valid = 1'b0; ilv_last = 1'b0;
      chk(ilv_bv === 1'b1 && ilv_ready === 1'b0, "R3 block closed, input stalled", 64'({ilv_bv, ilv_ready}), 64'b10);
      chk(ilv_blk === perm_fwd(lin), "R2/R4 permuted block", 64'(ilv_blk), 64'(perm_fwd(lin)));
      chk(ilv_bl === lst, "R5 last marker / padding", 64'(ilv_bl), 64'(lst));
      got = ilv_blk;
      @(negedge clk);
      chk(ilv_bv === 1'b1 && ilv_blk === got, "R6 hold without ready", 64'(ilv_blk), 64'(got));
      ilv_br = 1'b1;
      @(negedge clk);
      ilv_br = 1'b0;
      chk(ilv_bv === 1'b0 && ilv_ready === 1'b1, "R6 single take", 64'({ilv_bv, ilv_ready}), 64'b01);
      rx_round(got, lin, v == 1);
    end

    // R6: block after a padded one starts empty; a lone final symbol 2'b10
    @(negedge clk);
    ilv_valid = 1; ilv_data = 2'b10; ilv_last = 1;
    @(posedge clk);
    @(negedge clk);
    ilv_valid = 0; ilv_last = 0;
    chk(ilv_blk === perm_fwd(52'h2), "R6/R5 fresh block zero padded", 64'(ilv_blk), 64'(perm_fwd(52'h2)));
    ilv_br = 1'b1;
    @(negedge clk);
    chk(ilv_bv === 1'b0, "R6 pulse with ready high", 64'(ilv_bv), 64'd0);
    ilv_br = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule